// File: doc/BRIEF.md
# Atomic Set/Reset Output Port

This block holds the output state of a 16-bit general-purpose I/O port behind a small memory-mapped register bus. Software can change the output in two ways. It can write the output word directly, or it can write a 32-bit strobe word in which each output bit has its own "drive high" and "drive low" control. The strobe word changes any chosen group of bits in one bus write. No read-modify-write is needed, so bit-level updates need no interrupt masking. The strobe action is one-shot: it leaves nothing latched, and the output word stays directly writable at all times.

The block also returns the pin input levels through a read-only register, after a two-flop synchroniser. Byte strobes qualify every write lane by lane. An active-low reset enters asynchronously, and the block releases it internally on a clock edge.

Register map (byte addresses, 32-bit words): 0x0 pin input word (read-only), 0x4 output word (read/write), 0x8 strobe word (write-only), 0xC unmapped.

Top module: `gpio_bsr_port`

## Requirements
- R1: After reset, `pin_out` is 0x0000 and a read of the output word at 0x4 returns 0.
- R2: A write to 0x4 updates `pin_out` on the clock edge of the write, for the byte lanes whose strobe is 1. Lane 0 covers bits [7:0] and lane 1 covers bits [15:8]. A read of 0x4 returns the current output word, zero-extended.
- R3: In a write to 0x8, a 1 in bit i of [15:0] makes output bit i equal to 1 on the edge of the write.
- R4: In a write to 0x8, a 1 in bit 16+i makes output bit i equal to 0 on the edge of the write, provided bit i is not also 1.
- R5: Control bits written as 0 in a write to 0x8 leave their output bits unchanged. With no write, the output holds.
- R6: When bit i and bit 16+i are both 1 in a single write to 0x8, output bit i becomes 1.
- R7: A read of 0x8 returns 0. After any strobe write, a direct write to 0x4 still sets the output to the written value.
- R8: A read of 0x0 returns `pin_in` as it stood two clock edges earlier. A write to 0x0 has no effect on `pin_out`.
- R9: Byte strobes qualify writes to 0x8 lane by lane. Lanes 0 and 1 gate the set controls [15:0], and lanes 2 and 3 gate the reset controls [31:16].
- R10: A read of 0xC returns 0, and a write to 0xC leaves `pin_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released on a clock edge inside the block |
| bus_addr | input | 4 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte-lane write strobes |
| bus_wr | input | 1 | Write enable, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Pin input levels |
| pin_out | output | 16 | Output drive levels |

## Verification
The hardest case to reach from the ports is a strobe write that both sets and clears the same bit while a known neighbouring pattern sits in the output word. The priority rule and the "untouched bits hold" rule can only be seen together in that case. The bench reaches it by first loading the output word directly with all-zeros or all-ones. It then sweeps every bit position through all four set/clear combinations. After that, long pseudo-random strobe words and all sixteen strobe-lane masks are compared against an arithmetic model.

// File: rtl/gpio_bsr_pkg.sv
package gpio_bsr_pkg;

  typedef enum logic [1:0] {
    SEL_PIN   = 2'd0,
    SEL_OUT   = 2'd1,
    SEL_STRB  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/gpio_bsr_rst_sync.sv
module gpio_bsr_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) stage_q <= 2'b00;
    else              stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/gpio_bsr_in_sync.sv
module gpio_bsr_in_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins,
  output logic [WIDTH-1:0] pins_sync
);

  logic [WIDTH-1:0] meta_q, meta_d;
  logic [WIDTH-1:0] sync_q, sync_d;

  always_comb begin
    meta_d = pins;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign pins_sync = sync_q;

endmodule

// File: rtl/gpio_bsr_lane_mask.sv
module gpio_bsr_lane_mask #(
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic [STRB_W-1:0] strb,
  output logic [DATA_W-1:0] bit_mask
);

  for (genvar b = 0; b < STRB_W; b++) begin : g_lane
    assign bit_mask[b*8 +: 8] = {8{strb[b]}};
  end

endmodule

// File: rtl/gpio_bsr_out_reg.sv
module gpio_bsr_out_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dir,
  input  logic [WIDTH-1:0] dir_data,
  input  logic [WIDTH-1:0] dir_mask,
  input  logic             wr_sr,
  input  logic [WIDTH-1:0] set_bits,
  input  logic [WIDTH-1:0] clr_bits,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_d;
  logic             q_en;

  always_comb begin
    q_d  = q;
    q_en = wr_dir | wr_sr;
    if (wr_dir) q_d = (q & ~dir_mask) | (dir_data & dir_mask);
    if (wr_sr)  q_d = (q & ~clr_bits) | set_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

  p_direct_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> ((q ^ $past(dir_data)) & $past(dir_mask)) == '0);

  p_set_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sr |=> (q & $past(set_bits)) == $past(set_bits));

  p_clr_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sr |=> (q & $past(clr_bits & ~set_bits)) == '0);

  p_untouched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sr |=> ((q ^ $past(q)) & ~$past(set_bits | clr_bits)) == '0);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_dir && !wr_sr) |=> $stable(q));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sr && |(set_bits & clr_bits)) |=>
      (q & $past(set_bits & clr_bits)) == $past(set_bits & clr_bits));

endmodule

// File: rtl/gpio_bsr_port.sv
module gpio_bsr_port
  import gpio_bsr_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  localparam int STRB_W = DATA_W / 8,
  localparam int HALF   = DATA_W / 2,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [STRB_W-1:0] bus_strb,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out
);

  logic              rst_n_int;
  logic [WORD_W-1:0] word_idx;
  logic              unused_byte_off;
  reg_sel_e          sel;
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] wdata_masked;
  logic [WIDTH-1:0]  pins_sync;
  logic              wr_dir, wr_sr;

  gpio_bsr_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  assign word_idx        = bus_addr[ADDR_W-1:2];
  assign unused_byte_off = ^bus_addr[1:0];

  always_comb begin
    if      (word_idx == WORD_W'(0)) sel = SEL_PIN;
    else if (word_idx == WORD_W'(1)) sel = SEL_OUT;
    else if (word_idx == WORD_W'(2)) sel = SEL_STRB;
    else                             sel = SEL_NONE;
  end

  gpio_bsr_lane_mask #(.DATA_W(DATA_W)) u_lanes (
    .strb     (bus_strb),
    .bit_mask (lane_mask)
  );

  assign wdata_masked = bus_wdata & lane_mask;
  assign wr_dir       = bus_wr && (sel == SEL_OUT);
  assign wr_sr        = bus_wr && (sel == SEL_STRB);

  gpio_bsr_in_sync #(.WIDTH(WIDTH)) u_in (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .pins      (pin_in),
    .pins_sync (pins_sync)
  );

  gpio_bsr_out_reg #(.WIDTH(WIDTH)) u_out (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_dir   (wr_dir),
    .dir_data (bus_wdata[WIDTH-1:0]),
    .dir_mask (lane_mask[WIDTH-1:0]),
    .wr_sr    (wr_sr),
    .set_bits (wdata_masked[WIDTH-1:0]),
    .clr_bits (wdata_masked[HALF +: WIDTH]),
    .q        (pin_out)
  );

  always_comb begin
    case (sel)
      SEL_PIN: bus_rdata = DATA_W'(pins_sync);
      SEL_OUT: bus_rdata = DATA_W'(pin_out);
      default: bus_rdata = '0;
    endcase
  end

  p_strobe_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_addr[ADDR_W-1:2] == WORD_W'(2)) |-> (bus_rdata == '0));

  p_unmapped_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_addr[ADDR_W-1:2] == WORD_W'(3)) |-> (bus_rdata == '0));

  p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_wr && bus_addr[ADDR_W-1:2] == WORD_W'(3)) |=> $stable(pin_out));

  p_pin_word_write_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_wr && bus_addr[ADDR_W-1:2] == WORD_W'(0)) |=> $stable(pin_out));

endmodule

// File: tb/tb_gpio_bsr_port.sv
module tb_gpio_bsr_port;

  localparam logic [3:0] A_PIN  = 4'h0;
  localparam logic [3:0] A_OUT  = 4'h4;
  localparam logic [3:0] A_STRB = 4'h8;
  localparam logic [3:0] A_NONE = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_strb;
  logic        bus_wr;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in;
  logic [15:0] pin_out;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  gpio_bsr_port dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_strb  (bus_strb),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_strb = s; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #2;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] lanes(input logic [3:0] s);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{s[b]}};
    return m;
  endfunction

  function automatic logic [15:0] model_sr(input logic [15:0] old, input logic [31:0] d,
                                           input logic [3:0] s);
    logic [31:0] md;
    md = d & lanes(s);
    return (old & ~md[31:16]) | md[15:0];
  endfunction

  function automatic logic [15:0] model_dir(input logic [15:0] old, input logic [31:0] d,
                                            input logic [3:0] s);
    logic [15:0] m;
    m = lanes(s)[15:0];
    return (old & ~m) | (d[15:0] & m);
  endfunction

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [15:0] mdl;
    logic [31:0] r, lfsr;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_strb = '0; bus_wr = 1'b0;
    pin_in = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 pin_out", {16'h0, pin_out}, 32'h0);
    rd(A_OUT, r); chk("R1 out read", r, 32'h0);
    mdl = 16'h0;

    // R2 direct writes under every strobe mask
    for (int s = 0; s < 16; s++) begin
      logic [31:0] d;
      d = 32'h9E37_0000 | (32'h1111 * (s + 1));
      wr(A_OUT, d, 4'(s));
      mdl = model_dir(mdl, d, 4'(s));
      chk("R2 direct", {16'h0, pin_out}, {16'h0, mdl});
      rd(A_OUT, r); chk("R2 readback", r, {16'h0, mdl});
    end

    // R3 R4 R5 R6 per-bit sweep against a uniform prior pattern
    for (int i = 0; i < 16; i++) begin
      for (int p = 0; p < 2; p++) begin
        for (int c = 0; c < 4; c++) begin
          logic [31:0] d;
          logic [15:0] e;
          wr(A_OUT, (p != 0) ? 32'h0000_FFFF : 32'h0, 4'hF);
          d = ((c & 1) ? (32'h1 << i) : 32'h0) | ((c & 2) ? (32'h1 << (i + 16)) : 32'h0);
          wr(A_STRB, d, 4'hF);
          e = (p != 0) ? 16'hFFFF : 16'h0000;
          if (c & 1)      e[i] = 1'b1;
          else if (c & 2) e[i] = 1'b0;
          if (c == 3)      chk("R6 set wins", {16'h0, pin_out}, {16'h0, e});
          else if (c == 1) chk("R3 set", {16'h0, pin_out}, {16'h0, e});
          else if (c == 2) chk("R4 clear", {16'h0, pin_out}, {16'h0, e});
          else             chk("R5 no effect", {16'h0, pin_out}, {16'h0, e});
        end
      end
    end

    // R3 R4 R5 R6 pseudo-random strobe words, full lanes
    wr(A_OUT, 32'h0000_5AA5, 4'hF);
    mdl = 16'h5AA5;
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 300; k++) begin
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
      wr(A_STRB, lfsr, 4'hF);
      mdl = model_sr(mdl, lfsr, 4'hF);
      chk("R3 R4 R5 R6 random", {16'h0, pin_out}, {16'h0, mdl});
    end

    // R9 strobe lanes on the set/reset word
    for (int s = 0; s < 16; s++) begin
      wr(A_OUT, 32'h0000_0FF0, 4'hF);
      wr(A_STRB, 32'hF0F0_0F0F, 4'(s));
      chk("R9 lanes", {16'h0, pin_out}, {16'h0, model_sr(16'h0FF0, 32'hF0F0_0F0F, 4'(s))});
    end
    mdl = model_sr(16'h0FF0, 32'hF0F0_0F0F, 4'hF);

    // R7 strobe word reads zero, direct write still works after it
    rd(A_STRB, r); chk("R7 strobe read", r, 32'h0);
    wr(A_STRB, 32'hFFFF_0000, 4'hF);
    wr(A_OUT, 32'h0000_C3A5, 4'hF);
    chk("R7 direct after strobe", {16'h0, pin_out}, 32'h0000_C3A5);
    rd(A_STRB, r); chk("R7 strobe read after write", r, 32'h0);
    mdl = 16'hC3A5;

    // R8 two-edge input path, write to input word ignored
    @(negedge clk); pin_in = 16'hBEEF;
    @(negedge clk); rd(A_PIN, r); chk("R8 one edge old", r, 32'h0);
    @(negedge clk); rd(A_PIN, r); chk("R8 two edges new", r, 32'h0000_BEEF);
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); pin_in = 16'(v * 16'h1357);
      @(negedge clk); @(negedge clk);
      rd(A_PIN, r); chk("R8 pin sweep", r, {16'h0, 16'(v * 16'h1357)});
    end
    wr(A_PIN, 32'hFFFF_FFFF, 4'hF);
    chk("R8 pin word write ignored", {16'h0, pin_out}, {16'h0, mdl});

    // R10 unmapped word
    rd(A_NONE, r); chk("R10 unmapped read", r, 32'h0);
    wr(A_NONE, 32'hFFFF_FFFF, 4'hF);
    chk("R10 unmapped write", {16'h0, pin_out}, {16'h0, mdl});
    wr(A_NONE, 32'h0000_FFFF, 4'hF);
    chk("R10 unmapped set bits", {16'h0, pin_out}, {16'h0, mdl});

    // R5 idle hold
    repeat (5) @(negedge clk);
    chk("R5 idle hold", {16'h0, pin_out}, {16'h0, mdl});

    finish_run();
  end

endmodule